// File: doc/BRIEF.md
# DMA Channel Grant Scheduler

This block decides which DMA channel moves its next data element. Each channel supplies a configuration word and a remaining-element count. The configuration word carries:

- an enable bit and a halt bit;
- a flow-control type;
- a source peripheral number and a destination peripheral number, each 5 bits wide.

Two 32-bit peripheral request vectors, one for single requests and one for burst requests, are merged with a bitwise OR. The flow type selects which request bits must be present. Type 0 needs none. Type 1 needs the destination's bit. Type 2 needs the source's bit. Type 3 needs both.

While the global enable is on, an idle scheduler issues a registered one-hot grant to one eligible channel. It holds that grant until the transfer engine pulses done. Every grant moves exactly one element. A scan pointer remembers the last channel granted. After each element, that channel is offered the next grant first, so it keeps being served until it stops being eligible. Only then does the search move to higher channels, wrapping to the lowest one. Flow types that would hand control to the peripheral are not handled: such a channel is reported on a per-channel error vector and is never granted.

Top module: `dma_chan_sched`

## Requirements
- R1: A channel is a candidate only when bit 0 of its configuration word (enable) is 1 and bit 18 (halt) is 0.
- R2: The flow type is configuration bits [13:11], the source peripheral is bits [5:1] and the destination peripheral is bits [10:6]. A request bit counts as present when it is set in either `req_single` or `req_burst`.
- R3: Flow type 0 is eligible without requests. Type 1 needs the destination's request bit, type 2 needs the source's, and type 3 needs both.
- R4: For an enabled, unhalted channel with flow type 4 to 7, `flow_err[c]` is 1 while `glb_en` is 1. That channel is never granted.
- R5: A channel whose count input is zero is not eligible.
- R6: While `glb_en` is 0 no new grant is issued and `flow_err` is all zero.
- R7: `grant` is zero after reset and never has more than one bit set. While a grant is active, `grant_id` holds the index of the set bit.
- R8: An active grant stays unchanged until a cycle with `xfer_done` = 1. The grant is zero from the following clock edge on. `xfer_done` while no grant is active has no effect.
- R9: A new grant goes to the lowest eligible channel whose index is at least that of the channel granted last. If no such channel exists, it goes to the lowest eligible channel. The pointer is 0 after reset.
- R10: When the scheduler is idle and some channel is eligible at a clock edge, the grant is set at that edge. After a release, the scheduler spends one cycle idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global scheduler enable |
| chan_cfg | input | NCH*32 | Configuration words, channel c at bits [32c+31:32c] |
| chan_cnt | input | NCH*CNT_W | Remaining element counts, channel c at slice c |
| req_single | input | 32 | Single-transfer peripheral requests |
| req_burst | input | 32 | Burst-transfer peripheral requests |
| xfer_done | input | 1 | Engine finished the granted element |
| grant | output | NCH | One-hot channel grant |
| grant_id | output | IDX_W | Index of the granted channel |
| flow_err | output | NCH | Per-channel unsupported flow type flag |

## Verification
Directed patterns step one channel through each flow type. Each type is given the source bit alone, the destination bit alone, then both, with the bits split across the single and burst vectors, so a swapped peripheral field or a missing OR term shows up. Separate directed steps set only halt, clear only enable, zero the count, or choose a flow type above 3. Each of these must block the grant on its own. A scan sequence parks the pointer at a middle channel and then makes channels below and above it eligible, which tells lowest-first from pointer-first order. Random traffic with counts that shrink on each done exercises repeated service of one channel and the hand-over that follows.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  localparam int CFG_W    = 32;
  localparam int REQ_W    = 32;
  localparam int EN_BIT   = 0;
  localparam int HALT_BIT = 18;
  localparam int SRC_LSB  = 1;
  localparam int DST_LSB  = 6;
  localparam int FLOW_LSB = 11;

  typedef enum logic {SC_IDLE, SC_HOLD} sc_state_e;

  function automatic logic [2:0] cfg_flow(input logic [CFG_W-1:0] c);
    return c[FLOW_LSB +: 3];
  endfunction

  function automatic logic [4:0] cfg_src(input logic [CFG_W-1:0] c);
    return c[SRC_LSB +: 5];
  endfunction

  function automatic logic [4:0] cfg_dst(input logic [CFG_W-1:0] c);
    return c[DST_LSB +: 5];
  endfunction

  // request condition for the memory/peripheral flow types 0..3
  function automatic logic flow_req_met(input logic [1:0] fl,
                                        input logic [REQ_W-1:0] req,
                                        input logic [4:0] src,
                                        input logic [4:0] dst);
    logic s_ok, d_ok;
    s_ok = req[src];
    d_ok = req[dst];
    case (fl)
      2'd0:    return 1'b1;
      2'd1:    return d_ok;
      2'd2:    return s_ok;
      default: return s_ok & d_ok;
    endcase
  endfunction

endpackage

// File: rtl/chan_elig.sv
module chan_elig
  import dma_sched_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic [CNT_W-1:0] cnt,
  input  logic [REQ_W-1:0] req,
  output logic             elig,
  output logic             unsup
);
  logic       active;
  logic [2:0] fl;
  logic       unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg[CFG_W-1:HALT_BIT+1], cfg[HALT_BIT-1:FLOW_LSB+3]};
  assign active = cfg[EN_BIT] & ~cfg[HALT_BIT];
  assign fl     = cfg_flow(cfg);
  assign unsup  = active & fl[2];
  assign elig   = active & ~fl[2] & (cnt != '0)
                & flow_req_met(fl[1:0], req, cfg_src(cfg), cfg_dst(cfg));
endmodule

// File: rtl/scan_pick.sv
module scan_pick #(
  parameter int NCH   = 8,
  parameter int IDX_W = 3
) (
  input  logic [NCH-1:0]   cand,
  input  logic [IDX_W-1:0] ptr,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic             hi_hit;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_hit = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        lo_idx = IDX_W'(i);
        if (i >= int'(ptr)) begin
          hi_hit = 1'b1;
          hi_idx = IDX_W'(i);
        end
      end
    end
  end

  assign found = |cand;
  assign idx   = hi_hit ? hi_idx : lo_idx;
endmodule

// File: rtl/dma_chan_sched.sv
module dma_chan_sched
  import dma_sched_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int CNT_W = 12,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glb_en,
  input  logic [NCH*CFG_W-1:0] chan_cfg,
  input  logic [NCH*CNT_W-1:0] chan_cnt,
  input  logic [REQ_W-1:0]     req_single,
  input  logic [REQ_W-1:0]     req_burst,
  input  logic                 xfer_done,
  output logic [NCH-1:0]       grant,
  output logic [IDX_W-1:0]     grant_id,
  output logic [NCH-1:0]       flow_err
);
  logic [REQ_W-1:0] req_all;
  logic [NCH-1:0]   elig_vec, unsup_vec, cand_vec;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx, scan_ptr;
  sc_state_e        st;

  assign req_all = req_single | req_burst;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    chan_elig #(.CNT_W(CNT_W)) u_elig (
      .cfg  (chan_cfg[c*CFG_W +: CFG_W]),
      .cnt  (chan_cnt[c*CNT_W +: CNT_W]),
      .req  (req_all),
      .elig (elig_vec[c]),
      .unsup(unsup_vec[c])
    );
  end

  assign cand_vec = glb_en ? elig_vec  : '0;
  assign flow_err = glb_en ? unsup_vec : '0;

  scan_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
    .cand (cand_vec),
    .ptr  (scan_ptr),
    .found(pick_found),
    .idx  (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SC_IDLE;
      grant    <= '0;
      grant_id <= '0;
      scan_ptr <= '0;
    end else begin
      case (st)
        SC_IDLE: if (pick_found) begin
          grant    <= NCH'(1) << pick_idx;
          grant_id <= pick_idx;
          scan_ptr <= pick_idx;
          st       <= SC_HOLD;
        end
        default: if (xfer_done) begin
          grant <= '0;
          st    <= SC_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_sched_chk.sv
module dma_sched_chk #(
  parameter int NCH   = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic             xfer_done,
  input logic [NCH-1:0]   grant,
  input logic [IDX_W-1:0] grant_id,
  input logic [NCH-1:0]   flow_err,
  input logic [NCH-1:0]   cand,
  input logic             pick_found
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7
  AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> grant[grant_id]); // R7
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !xfer_done) |=> $stable(grant)); // R8
  AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && xfer_done) |=> (grant == '0)); // R8
  AST_OFF_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && !glb_en) |=> (grant == '0)); // R6
  AST_OFF_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (flow_err == '0)); // R6
  AST_GRANT_WAS_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> ((grant == '0) || ((grant & $past(cand)) != '0))); // R10
  AST_ERR_NOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> ((grant & $past(flow_err)) == '0)); // R4
  AST_IDLE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && pick_found) |=> (grant != '0)); // R10
endmodule

bind dma_chan_sched dma_sched_chk #(.NCH(NCH), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en),
  .xfer_done (xfer_done),
  .grant     (grant),
  .grant_id  (grant_id),
  .flow_err  (flow_err),
  .cand      (cand_vec),
  .pick_found(pick_found)
);

// File: tb/dma_chan_sched_test.sv
module dma_chan_sched_test;
  localparam int NCH = 8;
  localparam int CW  = 12;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            glb_en = 0;
  logic [NCH*32-1:0] chan_cfg;
  logic [NCH*CW-1:0] chan_cnt;
  logic [31:0]     req_single = 0, req_burst = 0;
  logic            xfer_done = 0;
  logic [NCH-1:0]  grant, flow_err;
  logic [2:0]      grant_id;

  logic [31:0]     cfg [NCH];
  logic [CW-1:0]   cnt [NCH];
  int              m_grant = -1;
  int              m_ptr = 0;
  int              n_chk = 0, n_bad = 0;
  bit              fin = 0;

  always #10 clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++) begin
      chan_cfg[c*32 +: 32] = cfg[c];
      chan_cnt[c*CW +: CW] = cnt[c];
    end

  dma_chan_sched #(.NCH(NCH), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .chan_cfg(chan_cfg),
    .chan_cnt(chan_cnt), .req_single(req_single), .req_burst(req_burst),
    .xfer_done(xfer_done), .grant(grant), .grant_id(grant_id),
    .flow_err(flow_err));

  function automatic logic [31:0] mk(bit en, bit halt, int fl, int src, int dst);
    logic [31:0] w = 0;
    w[0] = en; w[18] = halt;
    w[13:11] = fl[2:0]; w[5:1] = src[4:0]; w[10:6] = dst[4:0];
    return w;
  endfunction

  function automatic bit m_elig(int c);
    logic [31:0] r = req_single | req_burst;
    int fl = int'(cfg[c][13:11]);
    bit need_d = (fl == 1 || fl == 3);
    bit need_s = (fl == 2 || fl == 3);
    if (!glb_en || !cfg[c][0] || cfg[c][18] || fl >= 4 || cnt[c] == 0) return 0;
    if (need_d && !r[cfg[c][10:6]]) return 0;
    if (need_s && !r[cfg[c][5:1]]) return 0;
    return 1;
  endfunction

  function automatic int m_pick();
    for (int c = m_ptr; c < NCH; c++) if (m_elig(c)) return c;
    for (int c = 0; c < NCH; c++) if (m_elig(c)) return c;
    return -1;
  endfunction

  function automatic logic [NCH-1:0] m_err();
    logic [NCH-1:0] e = 0;
    for (int c = 0; c < NCH; c++)
      e[c] = glb_en && cfg[c][0] && !cfg[c][18] && (cfg[c][13:11] >= 3'd4);
    return e;
  endfunction

  task automatic tick(string tag);
    logic [NCH-1:0] exp_err, exp_g;
    exp_err = m_err();
    if (rst_n) begin
      if (m_grant < 0) begin
        int p = m_pick();
        if (p >= 0) begin m_grant = p; m_ptr = p; end
      end else if (xfer_done) m_grant = -1;
    end
    @(posedge clk); #2;
    exp_g = (m_grant < 0) ? '0 : NCH'(1) << m_grant;
    n_chk++;
    if (grant !== exp_g || flow_err !== exp_err ||
        (m_grant >= 0 && grant_id !== 3'(m_grant))) begin
      n_bad++;
      $display("FAIL %s: grant=%b id=%0d err=%b expected grant=%b id=%0d err=%b",
               tag, grant, grant_id, flow_err, exp_g, m_grant, exp_err);
    end
  endtask

  task automatic release_g(string tag);
    xfer_done = 1; tick(tag); xfer_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL R8: watchdog expired, actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin cfg[c] = 0; cnt[c] = 5; end
    tick("R7 reset"); tick("R7 reset");
    rst_n = 1;
    cfg[0] = mk(1, 0, 0, 0, 0);
    tick("R6 disabled"); tick("R6 disabled"); tick("R6 disabled");
    glb_en = 1;
    tick("R10 first grant");
    tick("R8 hold"); tick("R8 hold"); tick("R8 hold");
    release_g("R8 release");
    tick("R9 same channel again");
    release_g("R8 release");
    cfg[0] = mk(1, 1, 0, 0, 0); tick("R1 halted");
    cfg[0] = mk(0, 0, 0, 0, 0); tick("R1 not enabled");
    cfg[0] = mk(1, 0, 0, 0, 0); cnt[0] = 0; tick("R5 zero count");
    xfer_done = 1; tick("R8 done while idle"); xfer_done = 0;
    cnt[0] = 5; cfg[0] = 0;
    // flow type 1: destination 5, source 9
    cfg[2] = mk(1, 0, 1, 9, 5);
    req_burst = 32'h1 << 9; tick("R3 type1 source only");
    req_burst = 32'h1 << 5; tick("R2 type1 dest via burst");
    release_g("R8 release");
    req_burst = 0; req_single = 32'h1 << 5; tick("R2 type1 dest via single");
    release_g("R8 release");
    cfg[2] = mk(1, 0, 3, 9, 5); tick("R3 type3 dest only");
    req_burst = 32'h1 << 9; tick("R3 type3 both");
    release_g("R8 release");
    cfg[2] = mk(1, 0, 2, 9, 5); req_burst = 0; tick("R3 type2 dest only");
    req_burst = 32'h1 << 9; req_single = 0; tick("R3 type2 source");
    release_g("R8 release");
    cfg[2] = mk(1, 0, 6, 0, 0); req_single = '1; tick("R4 unsupported flow");
    cfg[2] = mk(1, 1, 5, 0, 0); tick("R4 halted unsupported");
    glb_en = 0; cfg[2] = mk(1, 0, 4, 0, 0); tick("R6 err masked"); glb_en = 1;
    cfg[2] = 0;
    cfg[3] = mk(1, 0, 0, 0, 0); tick("R9 park pointer");
    release_g("R8 release");
    cfg[3] = 0; cfg[1] = mk(1, 0, 0, 0, 0); cfg[5] = mk(1, 0, 0, 0, 0);
    tick("R9 above pointer first");
    release_g("R8 release");
    tick("R9 repeat");
    release_g("R8 release");
    cfg[5] = 0; tick("R9 wrap to lowest");
    release_g("R8 release");

    for (int k = 0; k < 4000; k++) begin
      int gch;
      if ($urandom % 6 == 0) begin
        int c = $urandom % NCH;
        int fl = ($urandom % 5 == 0) ? 4 + $urandom % 4 : $urandom % 4;
        cfg[c] = mk($urandom % 5 != 0, $urandom % 8 == 0, fl, $urandom % 32, $urandom % 32);
        cnt[c] = ($urandom % 4 == 0) ? '0 : CW'(1 + $urandom % 6);
      end
      req_single = $urandom & $urandom;
      req_burst  = $urandom & $urandom & $urandom;
      if ($urandom % 40 == 0) glb_en = ~glb_en;
      xfer_done = (m_grant >= 0) ? ($urandom % 3 == 0) : ($urandom % 4 == 0);
      gch = xfer_done ? m_grant : -1;
      tick("R9 random traffic");
      if (gch >= 0 && cnt[gch] != 0) cnt[gch] = cnt[gch] - 1'b1;
    end
    xfer_done = 0;
    fin = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule